// File: doc/BRIEF.md
# Sticky Interrupt Source Controller

The block gathers six level-sensitive interrupt causes into a sticky source register and drives a single interrupt request line. A cause that is high at a clock edge sets its source bit, whatever the enable state. The bit then stays set after the cause falls. Software enables bits through a set-enable register and a clear-enable register. The request line is high whenever an enabled source bit is set.

Software acknowledges a source bit by writing a 1 to it. The acknowledge is accepted only if the cause for that bit is low in the cycle of the write. If the cause is still high, the bit stays set. When that bit is also enabled, the request line drops for exactly one cycle and then rises again. An edge-sensitive interrupt controller downstream therefore sees a new interrupt.

The register port is a simple single-cycle write strobe with a two-bit word address. Read data is combinational from the address.

Top module: `irq_sticky_ctrl`

## Requirements
- R1: After synchronous reset, the source register and the enable register both read as zero and `irq_o` is low.
- R2: A cause input that is high at a rising clock edge sets its source bit, whether or not the bit is enabled. Cause bit positions are: 0 waveform capture done, 1 any channel fault, 2 any magnet fault, 3 timing receiver interrupt, 4 message available, 5 general-purpose input. Address 0 reads the source register.
- R3: Bits above bit 5 always read as zero at addresses 0 and 1. Addresses 2 and 3 read as zero.
- R4: A write to address 0 clears each source bit whose write-data bit is 1 and whose cause is low in that cycle. Source bits written with 0 are unchanged.
- R5: A source bit written with 1 at address 0 while its cause is still high stays set.
- R6: When an acknowledge is rejected on an enabled bit, `irq_o` is low in the cycle after the write. It is high again one cycle later if that bit is still set and enabled.
- R7: A write to address 2 sets each enable bit whose data bit is 1 and leaves all other enable bits unchanged. Address 1 reads the enable register.
- R8: A write to address 3 clears each enable bit whose data bit is 1 and leaves all other enable bits unchanged.
- R9: Outside the one-cycle gap of R6, `irq_o` is the OR over all bits of source AND enable.
- R10: A set source bit remains set after its cause falls, until an accepted acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_i | input | 6 | Level interrupt causes, synchronous to clk |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 2 | Word address: 0 source, 1 enable, 2 set-enable, 3 clear-enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current address |
| irq_o | output | 1 | Interrupt request |

## Verification
Each register in the block is visible at the ports one cycle after it changes. A source bit that is lost, stuck or wrongly cleared shows up on the read of address 0 right after the edge. An enable bit that is set or cleared too widely shows up on the read of address 1 in the same way. Faults in the rejected-acknowledge path appear at `irq_o`: a missing gap, or a gap that lasts too long, is seen in the first or second cycle after the write. A cause-versus-acknowledge priority error shows up as a source bit that is cleared even though its cause is high.

// File: rtl/irq_sticky_pkg.sv
package irq_sticky_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_SRC    = 2'd0,
        SEL_EN     = 2'd1,
        SEL_EN_SET = 2'd2,
        SEL_EN_CLR = 2'd3
    } reg_sel_e;

    function automatic logic wr_hits(input logic wr, input reg_sel_e sel,
                                     input reg_sel_e target);
        return wr && (sel == target);
    endfunction

endpackage

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_sticky_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int DATA_W  = 32
) (
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [NUM_SRC-1:0] wdata_lo_i,
    input  logic [NUM_SRC-1:0] src_q_i,
    input  logic [NUM_SRC-1:0] en_q_i,
    output logic [NUM_SRC-1:0] ack_o,
    output logic [NUM_SRC-1:0] set_o,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [DATA_W-1:0]  rdata_o
);

    reg_sel_e sel;

    assign sel = reg_sel_e'(reg_addr_i);

    always_comb begin
        ack_o = '0;
        set_o = '0;
        clr_o = '0;
        if (wr_hits(reg_wr_i, sel, SEL_SRC))    ack_o = wdata_lo_i;
        if (wr_hits(reg_wr_i, sel, SEL_EN_SET)) set_o = wdata_lo_i;
        if (wr_hits(reg_wr_i, sel, SEL_EN_CLR)) clr_o = wdata_lo_i;
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_SRC: rdata_o[NUM_SRC-1:0] = src_q_i;
            SEL_EN:  rdata_o[NUM_SRC-1:0] = en_q_i;
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] cause_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] src_q_o,
    output logic [NUM_SRC-1:0] reject_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)             src_q_o[g] <= 1'b0;
            else if (cause_i[g]) src_q_o[g] <= 1'b1;
            else if (ack_i[g])   src_q_o[g] <= 1'b0;
        end
        assign reject_o[g] = ack_i[g] & cause_i[g];
    end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] en_q_o
);

    always_ff @(posedge clk) begin
        if (rst) en_q_o <= '0;
        else     en_q_o <= (en_q_o | set_i) & ~clr_i;
    end

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_q_i,
    input  logic [NUM_SRC-1:0] en_q_i,
    input  logic [NUM_SRC-1:0] reject_i,
    output logic               irq_o
);

    logic gap_q;

    always_ff @(posedge clk) begin
        if (rst) gap_q <= 1'b0;
        else     gap_q <= |(reject_i & en_q_i);
    end

    assign irq_o = (|(src_q_i & en_q_i)) & ~gap_q;

endmodule

// File: rtl/irq_sticky_ctrl.sv
module irq_sticky_ctrl
    import irq_sticky_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] cause_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] ack;
    logic [NUM_SRC-1:0] en_set;
    logic [NUM_SRC-1:0] en_clr;
    logic [NUM_SRC-1:0] reject;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:NUM_SRC];

    irq_reg_port #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_port (
        .reg_wr_i   (reg_wr_i),
        .reg_addr_i (reg_addr_i),
        .wdata_lo_i (reg_wdata_i[NUM_SRC-1:0]),
        .src_q_i    (src_q),
        .en_q_i     (en_q),
        .ack_o      (ack),
        .set_o      (en_set),
        .clr_o      (en_clr),
        .rdata_o    (reg_rdata_o)
    );

    irq_src_bank #(.NUM_SRC(NUM_SRC)) u_src (
        .clk      (clk),
        .rst      (rst),
        .cause_i  (cause_i),
        .ack_i    (ack),
        .src_q_o  (src_q),
        .reject_o (reject)
    );

    irq_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
        .clk    (clk),
        .rst    (rst),
        .set_i  (en_set),
        .clr_i  (en_clr),
        .en_q_o (en_q)
    );

    irq_req_gen #(.NUM_SRC(NUM_SRC)) u_req (
        .clk      (clk),
        .rst      (rst),
        .src_q_i  (src_q),
        .en_q_i   (en_q),
        .reject_i (reject),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/irq_sticky_ctrl_chk.sv
module irq_sticky_ctrl_chk #(
    parameter int NUM_SRC = 6,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] cause_i,
    input logic               reg_wr_i,
    input logic [1:0]         reg_addr_i,
    input logic [NUM_SRC-1:0] wdata_lo,
    input logic [NUM_SRC-1:0] src_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic               irq_o
);

    logic [NUM_SRC-1:0] ack_v;
    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] clr_v;

    assign ack_v = (reg_wr_i && reg_addr_i == 2'd0) ? wdata_lo : '0;
    assign set_v = (reg_wr_i && reg_addr_i == 2'd2) ? wdata_lo : '0;
    assign clr_v = (reg_wr_i && reg_addr_i == 2'd3) ? wdata_lo : '0;

    AST_CAUSE_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((src_q & $past(cause_i)) == $past(cause_i)));  // R2

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata_o[DATA_W-1:NUM_SRC] == '0);  // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (|(ack_v & ~cause_i)) |=> ((src_q & $past(ack_v & ~cause_i)) == '0));  // R4

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (|(ack_v & cause_i)) |=> ((src_q & $past(ack_v & cause_i)) == $past(ack_v & cause_i)));  // R5

    AST_REJECT_GAP: assert property (@(posedge clk) disable iff (rst)
        (|(ack_v & cause_i & en_q)) |=> !irq_o);  // R6

    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        (|set_v) |=> ((en_q & $past(set_v)) == $past(set_v)));  // R7

    AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
        (|clr_v) |=> ((en_q & $past(clr_v)) == '0));  // R8

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !(|(ack_v & cause_i & en_q)) |=> (irq_o == |(src_q & en_q)));  // R9

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(src_q) & ~$past(ack_v)) & ~src_q) == '0));  // R10

endmodule

bind irq_sticky_ctrl irq_sticky_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cause_i     (cause_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .wdata_lo    (reg_wdata_i[NUM_SRC-1:0]),
    .src_q       (src_q),
    .en_q        (en_q),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
);

// File: tb/irq_sticky_ctrl_tb.sv
module irq_sticky_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  cause = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [5:0] m_src = '0;
    logic [5:0] m_en  = '0;
    logic       m_gap = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_sticky_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .cause_i     (cause),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [5:0] exp_src(logic [5:0] s, logic [5:0] c, logic [5:0] a);
        return c | (s & ~a);
    endfunction

    function automatic logic [5:0] exp_en(logic [5:0] e, logic [5:0] s, logic [5:0] c);
        return (e | s) & ~c;
    endfunction

    function automatic logic exp_irq(logic [5:0] s, logic [5:0] e, logic g);
        return (|(s & e)) & ~g;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        logic [5:0] a, s, c;
        logic [5:0] n_src, n_en;
        logic       n_gap;
        a = (wr && addr == 2'd0) ? wdata[5:0] : 6'd0;
        s = (wr && addr == 2'd2) ? wdata[5:0] : 6'd0;
        c = (wr && addr == 2'd3) ? wdata[5:0] : 6'd0;
        n_src = exp_src(m_src, cause, a);
        n_en  = exp_en(m_en, s, c);
        n_gap = |(a & cause & m_en);
        @(posedge clk);
        #1;
        m_src = n_src;
        m_en  = n_en;
        m_gap = n_gap;
        wr    = 1'b0;
    endtask

    task automatic check_model(string t_irq, string t_src, string t_en, string t_hi);
        addr = 2'd0; #1; chk(t_src, rdata, {26'd0, m_src});
        addr = 2'd1; #1; chk(t_en,  rdata, {26'd0, m_en});
        addr = 2'd2; #1; chk(t_hi,  rdata, 32'd0);
        addr = 2'd3; #1; chk(t_hi,  rdata, 32'd0);
        chk(t_irq, {31'd0, irq}, {31'd0, exp_irq(m_src, m_en, m_gap)});
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
    endtask

    task automatic read_at(logic [1:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1; cause = '0; wr = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        m_src = '0; m_en = '0; m_gap = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int          seed;
        seed = $urandom(32'h1F2E3D4C);

        do_reset();
        check_model("R1", "R1", "R1", "R1");
        chk("R1", {31'd0, irq}, 32'd0);

        // R2: each cause alone sets only its own bit, enables all zero
        for (int i = 0; i < 6; i++) begin
            do_reset();
            cause = 6'd1 << i;
            step();
            cause = '0;
            read_at(2'd0, d);
            chk("R2", d, 32'd1 << i);
            chk("R9", {31'd0, irq}, 32'd0);
            step(); step();
            read_at(2'd0, d);
            chk("R10", d, 32'd1 << i);
        end

        // R4: accepted ack on bit 3 leaves bit 0 alone
        do_reset();
        cause = 6'b001001; step(); cause = '0;
        reg_write(2'd0, 32'h0000_0008); step();
        read_at(2'd0, d);
        chk("R4", d, 32'h0000_0001);

        // R3: all enables set, upper bits zero
        cause = 6'b111111; reg_write(2'd2, 32'hFFFF_FFFF); step();
        read_at(2'd1, d); chk("R3", d, 32'h0000_003F);
        read_at(2'd0, d); chk("R3", d, 32'h0000_003F);
        read_at(2'd2, d); chk("R3", d, 32'h0000_0000);
        cause = '0;

        // R7 / R8: enable set and clear touch only their bits
        do_reset();
        reg_write(2'd2, 32'h0000_0005); step();
        reg_write(2'd2, 32'h0000_0002); step();
        read_at(2'd1, d); chk("R7", d, 32'h0000_0007);
        reg_write(2'd3, 32'h0000_0004); step();
        read_at(2'd1, d); chk("R8", d, 32'h0000_0003);

        // R5 / R6: rejected ack on enabled bit 1
        cause = 6'b000010; step();
        chk("R9", {31'd0, irq}, 32'd1);
        reg_write(2'd0, 32'h0000_0002); step();
        chk("R6", {31'd0, irq}, 32'd0);
        read_at(2'd0, d); chk("R5", d, 32'h0000_0002);
        step();
        chk("R6", {31'd0, irq}, 32'd1);
        cause = '0;
        reg_write(2'd0, 32'h0000_0002); step();
        read_at(2'd0, d); chk("R4", d, 32'h0000_0000);
        chk("R9", {31'd0, irq}, 32'd0);

        // Rejected ack on a disabled bit causes no gap on an enabled one
        cause = 6'b000101; reg_write(2'd3, 32'h0000_0002); step();
        reg_write(2'd2, 32'h0000_0001); step();
        reg_write(2'd0, 32'h0000_0004); step();
        chk("R9", {31'd0, irq}, 32'd1);
        cause = '0;

        // Random phase against the bench model
        do_reset();
        for (int n = 0; n < 400; n++) begin
            int op;
            cause = 6'($urandom & $urandom & $urandom);
            op = $urandom_range(0, 5);
            case (op)
                1: reg_write(2'd0, $urandom);
                2: reg_write(2'd2, $urandom & $urandom);
                3: reg_write(2'd3, $urandom & $urandom);
                4: reg_write(2'd0, 32'hFFFF_FFFF);
                5: reg_write(2'd1, $urandom);
                default: wr = 1'b0;
            endcase
            step();
            check_model("R9", "R4", "R7", "R3");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule